// File: doc/BRIEF.md
# Clock Source Switch Controller

This block chooses which of three oscillator sources clocks the system: a low-frequency internal RC, a fast internal oscillator, or a primary external oscillator. Its inputs are a run-mode field, a frequency-select field and a source-select bit for the fast internal oscillator, a PLL enable, and the watchdog and fail-safe-monitor enables. The oscillators themselves are modelled as tick strobes. The block drives an enable for each oscillator, a one-hot gate-enable vector for the clock gating cells, an encoded clock-select, and two status flags. One flag says the fast internal source is stable. The other says the primary source has completed start-up and is clocking the device.

The device always keeps running on the source it already has. A new source is chosen only when it is ready. The fast internal oscillator is ready after a stabilization count. The primary is ready after a start-up count of its own cycles, followed by a PLL lock count of reference ticks when the PLL is on. The handover itself is break-before-make. The old gate is removed first. A synchronizer clocked by the new source's ticks must then see the request before the new gate opens, so no runt clock pulse can reach the system.

Top module: `csw_ctrl`

## Requirements
- R1: On synchronous active-high reset, `clk_sel` is 0 (low-frequency RC), `gate_en` is 3'b001, and `int_stable` and `pri_ready` are 0.
- R2: While `freq_sel` is zero and `int_src` is 0 in an internal run mode, `fast_osc_en` and `int_stable` stay 0 and the clock stays on the low-frequency RC.
- R3: When `freq_sel` becomes non-zero or `int_src` is set, `fast_osc_en` rises in the same cycle. `int_stable` rises only after `INT_STAB_TICKS` fast ticks, and the clock keeps running from the RC gate meanwhile.
- R4: If the fast source is already stable, changing `freq_sel` between non-zero values or setting `int_src` leaves `int_stable` high and the clock on the fast source, with no new wait.
- R5: `mode_sel` = 2'b00 selects primary run, and any other value is internal run. In primary run, `pri_osc_en` is 1 and the clock stays on the internal source until `OST_CYCLES` primary ticks have been counted.
- R6: With `pll_en` high when the start-up count ends, a further `PLL_LOCK_TICKS` reference ticks are required before the switch to primary starts.
- R7: When the switch to primary completes, `int_stable` falls and `pri_ready` rises in the same cycle. The two flags are never high together.
- R8: While the primary clocks the device, `lfrc_en` is 1 if `wdt_en` or `fscm_en` is 1, and 0 otherwise.
- R9: `gate_en` is one-hot or zero, and bit i gates source i (0 RC, 1 fast, 2 primary; `clk_sel` uses the same codes). A switch first drives `gate_en` to zero. The new gate and `clk_sel` change one cycle after the second tick of the new source that follows.
- R10: Once a switch has started, its destination is fixed. A request change during the switch takes effect only after the switch completes.
- R11: Returning from primary to an internal run mode keeps `pri_osc_en` high until the switch away completes. `pri_ready` then clears in the same cycle that `int_stable` returns, and `pri_osc_en` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Run mode: 2'b00 primary, otherwise internal |
| freq_sel | input | FSEL_W | Fast internal frequency select, zero means off |
| int_src | input | 1 | Forces the fast internal oscillator on |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| pll_en | input | 1 | PLL in use on the primary path |
| pri_tick | input | 1 | Primary oscillator cycle strobe |
| fast_tick | input | 1 | Fast internal oscillator cycle strobe |
| lfrc_tick | input | 1 | Low-frequency RC cycle strobe |
| ref_tick | input | 1 | Reference strobe for the PLL lock count |
| clk_sel | output | 2 | Active source code |
| gate_en | output | 3 | One-hot clock gate enables |
| pri_osc_en | output | 1 | Primary oscillator enable |
| fast_osc_en | output | 1 | Fast internal oscillator enable |
| lfrc_en | output | 1 | Low-frequency RC enable |
| int_stable | output | 1 | Fast internal source stable flag |
| pri_ready | output | 1 | Primary start-up done and in use |

## Verification
The assertions check the structural rules on every cycle. These are: the one-hot or zero gate vector, a dark gate during a switch, a fixed destination while a switch is in progress, every gated source having its oscillator enabled, and the two flags never being high together. Only the bench scenarios can show the counted quantities: the exact number of primary, reference and fast ticks before a flag or a switch. They also show the same-cycle flag exchange, the RC staying on for the watchdog, and a request that changes in the middle of a switch.

// File: rtl/csw_pkg.sv
package csw_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_LFRC = 2'd0,
        SRC_FAST = 2'd1,
        SRC_PRI  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        TM_COUNT = 2'd0,
        TM_LOCK  = 2'd1,
        TM_READY = 2'd2
    } tmr_e;

    typedef enum logic {
        HO_IDLE = 1'b0,
        HO_SYNC = 1'b1
    } ho_e;

    function automatic logic [NUM_SRC-1:0] src_onehot(src_e s);
        return NUM_SRC'(1) << s;
    endfunction
endpackage

// File: rtl/csw_startup_timer.sv
module csw_startup_timer
    import csw_pkg::*;
#(
    parameter int OST_CYCLES     = 1024,
    parameter int PLL_LOCK_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic pll_en,
    input  logic osc_tick,
    input  logic ref_tick,
    output logic ready
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MAXC = (OST_CYCLES > PLL_LOCK_TICKS) ? OST_CYCLES : PLL_LOCK_TICKS;
    localparam int CW   = $clog2(MAXC + 1);

    tmr_e           st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st  <= TM_COUNT;
            cnt <= '0;
        end else begin
            case (st)
                TM_COUNT: if (osc_tick) begin
                    if (cnt == CW'(OST_CYCLES - 1)) begin
                        cnt <= '0;
                        st  <= pll_en ? TM_LOCK : TM_READY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TM_LOCK: if (ref_tick) begin
                    if (cnt == CW'(PLL_LOCK_TICKS - 1)) begin
                        cnt <= '0;
                        st  <= TM_READY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= TM_READY;
            endcase
        end
    end

    assign ready = (st == TM_READY);

    // R5: readiness only exists while the primary path stayed enabled
    a_r5_ready_needs_enable: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(enable));

    // R6: leaving the lock phase is always caused by a reference tick
    a_r6_lock_exit_on_ref: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == TM_LOCK && st == TM_READY) |-> $past(ref_tick));
endmodule

// File: rtl/csw_int_stab.sv
module csw_int_stab #(
    parameter int STAB_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic osc_tick,
    output logic ok
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(STAB_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
            ok  <= 1'b0;
        end else if (!ok && osc_tick) begin
            if (cnt == CW'(STAB_TICKS - 1)) begin
                ok <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: stability is declared on an oscillator tick, never spontaneously
    a_r3_ok_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(ok) |-> $past(osc_tick));
endmodule

// File: rtl/csw_handover.sv
module csw_handover
    import csw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  src_e               target,
    input  logic [NUM_SRC-1:0] src_tick,
    output src_e               cur,
    output src_e               nxt,
    output logic               busy,
    output logic [NUM_SRC-1:0] gate_en
);
    timeunit 1ns;
    timeprecision 1ps;

    ho_e                    st;
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= HO_IDLE;
            cur     <= SRC_LFRC;
            nxt     <= SRC_LFRC;
            gate_en <= src_onehot(SRC_LFRC);
            sync_q  <= '0;
        end else begin
            case (st)
                HO_IDLE: if (target != cur) begin
                    nxt     <= target;
                    gate_en <= '0;
                    sync_q  <= '0;
                    st      <= HO_SYNC;
                end
                default: begin
                    if (sync_q[SYNC_STAGES-1]) begin
                        cur     <= nxt;
                        gate_en <= src_onehot(nxt);
                        st      <= HO_IDLE;
                    end else if (src_tick[nxt]) begin
                        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
                    end
                end
            endcase
        end
    end

    assign busy = (st == HO_SYNC);

    // R9: never two gates open at once
    a_r9_gate_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_en));

    // R9: every gate is closed while a switch is in flight
    a_r9_dark_during_switch: assert property (@(posedge clk) disable iff (rst)
        busy |-> (gate_en == '0));

    // R10: the destination of a switch cannot move mid-flight
    a_r10_dest_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(nxt));
endmodule

// File: rtl/csw_ctrl.sv
module csw_ctrl
    import csw_pkg::*;
#(
    parameter int FSEL_W         = 3,
    parameter int OST_CYCLES     = 1024,
    parameter int PLL_LOCK_TICKS = 8,
    parameter int INT_STAB_TICKS = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [FSEL_W-1:0] freq_sel,
    input  logic              int_src,
    input  logic              wdt_en,
    input  logic              fscm_en,
    input  logic              pll_en,
    input  logic              pri_tick,
    input  logic              fast_tick,
    input  logic              lfrc_tick,
    input  logic              ref_tick,
    output logic [1:0]        clk_sel,
    output logic [2:0]        gate_en,
    output logic              pri_osc_en,
    output logic              fast_osc_en,
    output logic              lfrc_en,
    output logic              int_stable,
    output logic              pri_ready
);
    timeunit 1ns;
    timeprecision 1ps;

    src_e               cur;
    src_e               nxt;
    src_e               target;
    logic               busy;
    logic               pri_rdy;
    logic               int_ok;
    logic               run_int;
    logic               fast_req;
    logic               fast_ok;
    logic [NUM_SRC-1:0] src_tick;
    logic [NUM_SRC-1:0] src_en;

    assign run_int  = (mode_sel != 2'b00);
    assign fast_req = (freq_sel != '0) || int_src;
    assign fast_ok  = fast_req && int_ok;

    // an oscillator runs if demanded, in use, or the destination of a switch
    assign fast_osc_en = fast_req || (cur == SRC_FAST) || (busy && nxt == SRC_FAST);
    assign pri_osc_en  = !run_int || (cur == SRC_PRI) || (busy && nxt == SRC_PRI);
    assign lfrc_en     = (cur != SRC_PRI) || wdt_en || fscm_en || (busy && nxt == SRC_LFRC);

    assign src_tick = {pri_tick, fast_tick, lfrc_tick};
    assign src_en   = {pri_osc_en, fast_osc_en, lfrc_en};

    always_comb begin
        if (run_int) begin
            target = fast_ok ? SRC_FAST : SRC_LFRC;
        end else if (pri_rdy) begin
            target = SRC_PRI;
        end else if (cur == SRC_FAST && !fast_ok) begin
            target = SRC_LFRC;
        end else begin
            target = cur;
        end
    end

    csw_startup_timer #(
        .OST_CYCLES    (OST_CYCLES),
        .PLL_LOCK_TICKS(PLL_LOCK_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .enable  (!run_int),
        .pll_en  (pll_en),
        .osc_tick(pri_tick),
        .ref_tick(ref_tick),
        .ready   (pri_rdy)
    );

    csw_int_stab #(
        .STAB_TICKS(INT_STAB_TICKS)
    ) u_stab (
        .clk     (clk),
        .rst     (rst),
        .enable  (fast_osc_en),
        .osc_tick(fast_tick),
        .ok      (int_ok)
    );

    csw_handover #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_handover (
        .clk     (clk),
        .rst     (rst),
        .target  (target),
        .src_tick(src_tick),
        .cur     (cur),
        .nxt     (nxt),
        .busy    (busy),
        .gate_en (gate_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_stable <= 1'b0;
            pri_ready  <= 1'b0;
        end else begin
            int_stable <= fast_ok && (cur != SRC_PRI);
            pri_ready  <= (cur == SRC_PRI);
        end
    end

    assign clk_sel = cur;

    // R7: the two status flags are mutually exclusive
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(int_stable && pri_ready));

    // R5: in primary run the primary is only in use once the timer is done
    a_r5_pri_after_timer: assert property (@(posedge clk) disable iff (rst)
        (cur == SRC_PRI && !run_int) |-> pri_rdy);

    // R8: with the primary in use, the RC stays on for watchdog or monitor
    a_r8_rc_kept: assert property (@(posedge clk) disable iff (rst)
        (pri_ready && (wdt_en || fscm_en)) |-> lfrc_en);

    // R2: no fast request means no stable flag on the next cycle
    a_r2_flag_low_when_off: assert property (@(posedge clk) disable iff (rst)
        !fast_req |=> !int_stable);

    // R9: an open gate always has its oscillator running
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate_chk
        a_r9_gated_src_running: assert property (@(posedge clk) disable iff (rst)
            gate_en[g] |-> src_en[g]);
    end
endmodule

// File: tb/csw_ctrl_bench.sv
module csw_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int OST  = 1024;
    localparam int PLLN = 8;
    localparam int STAB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b10;
    logic [2:0] freq_sel = '0;
    logic       int_src = 1'b0, wdt_en = 1'b0, fscm_en = 1'b0, pll_en = 1'b0;
    logic       pri_auto = 1'b0, pri_man = 1'b0, auto_pri = 1'b0;
    logic       fast_tick = 1'b0, lfrc_tick = 1'b0, ref_tick = 1'b0;
    logic       pri_tick;
    logic [1:0] clk_sel;
    logic [2:0] gate_en;
    logic       pri_osc_en, fast_osc_en, lfrc_en, int_stable, pri_ready;

    int n_chk = 0;
    int n_bad = 0;
    int fast_cnt = 0;

    assign pri_tick = pri_auto | pri_man;

    always #2.5 clk = ~clk;

    csw_ctrl u_csw_ctrl (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .freq_sel(freq_sel),
        .int_src(int_src), .wdt_en(wdt_en), .fscm_en(fscm_en), .pll_en(pll_en),
        .pri_tick(pri_tick), .fast_tick(fast_tick), .lfrc_tick(lfrc_tick),
        .ref_tick(ref_tick), .clk_sel(clk_sel), .gate_en(gate_en),
        .pri_osc_en(pri_osc_en), .fast_osc_en(fast_osc_en), .lfrc_en(lfrc_en),
        .int_stable(int_stable), .pri_ready(pri_ready)
    );

    // oscillator models: tick only while enabled
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            pri_auto  = auto_pri && pri_osc_en && (cyc % 2 == 0);
            fast_tick = fast_osc_en && (cyc % 3 == 0);
            lfrc_tick = lfrc_en && (cyc % 5 == 0);
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (fast_tick) fast_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 gate_en", gate_en, 1);
        chk("R1 int_stable", int_stable, 0);
        chk("R1 pri_ready", pri_ready, 0);
        rst = 1'b0;
    endtask

    task automatic t_idle_rc();
        repeat (60) @(negedge clk);
        chk("R2 fast_osc_en", fast_osc_en, 0);
        chk("R2 int_stable", int_stable, 0);
        chk("R2 clk_sel", clk_sel, 0);
        chk("R2 gate_en", gate_en, 1);
    endtask

    task automatic t_fast_on();
        int c0, c1;
        freq_sel = 3'd3;
        c0 = fast_cnt;
        @(negedge clk);
        chk("R3 fast_osc_en", fast_osc_en, 1);
        chk("R3 int_stable early", int_stable, 0);
        chk("R3 gate held", gate_en, 1);
        for (int k = 0; k < 400 && gate_en == 3'b001; k++) @(negedge clk);
        chk("R9 gate dark", gate_en, 0);
        chk("R3 int_stable", int_stable, 1);
        chk("R3 stab ticks", (fast_cnt - c0 >= STAB) ? 1 : 0, 1);
        c1 = fast_cnt;
        for (int k = 0; k < 100 && gate_en == 3'b000; k++) @(negedge clk);
        chk("R9 new gate", gate_en, 2);
        chk("R9 clk_sel", clk_sel, 1);
        chk("R9 sync ticks", (fast_cnt - c1 >= 2) ? 1 : 0, 1);
    endtask

    task automatic t_stay_stable();
        int bad = 0;
        freq_sel = 3'd5;
        int_src  = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (int_stable !== 1'b1 || clk_sel !== 2'd1) bad++;
        end
        chk("R4 no new wait", bad, 0);
        int_src = 1'b0;
        @(negedge clk);
        chk("R4 int_stable", int_stable, 1);
    endtask

    task automatic t_midswitch();
        freq_sel = 3'd0;
        int_src  = 1'b0;
        for (int k = 0; k < 20 && gate_en == 3'b010; k++) @(negedge clk);
        chk("R10 dark", gate_en, 0);
        freq_sel = 3'd3;
        for (int k = 0; k < 100 && gate_en == 3'b000; k++) @(negedge clk);
        chk("R10 first dest", gate_en, 1);
        chk("R10 clk_sel", clk_sel, 0);
        for (int k = 0; k < 100 && gate_en == 3'b001; k++) @(negedge clk);
        for (int k = 0; k < 100 && gate_en == 3'b000; k++) @(negedge clk);
        chk("R10 return", gate_en, 2);
    endtask

    task automatic t_primary();
        logic p_int, p_pri;
        mode_sel = 2'b00;
        @(negedge clk);
        chk("R5 pri_osc_en", pri_osc_en, 1);
        for (int k = 0; k < OST - 1; k++) begin
            pri_man = 1'b1;
            @(negedge clk);
            pri_man = 1'b0;
            @(negedge clk);
        end
        repeat (8) @(negedge clk);
        chk("R5 still internal", clk_sel, 1);
        chk("R5 pri_ready", pri_ready, 0);
        pri_man = 1'b1;
        @(negedge clk);
        pri_man = 1'b0;
        auto_pri = 1'b1;
        p_int = int_stable;
        p_pri = pri_ready;
        for (int k = 0; k < 60 && pri_ready == 1'b0; k++) begin
            p_int = int_stable;
            p_pri = pri_ready;
            @(negedge clk);
        end
        chk("R7 pri_ready", pri_ready, 1);
        chk("R7 int_stable fell", int_stable, 0);
        chk("R7 prev int_stable", p_int, 1);
        chk("R7 prev pri_ready", p_pri, 0);
        chk("R5 clk_sel", clk_sel, 2);
        chk("R5 gate", gate_en, 4);
    endtask

    task automatic t_rc_keep();
        wdt_en = 1'b0; fscm_en = 1'b0;
        @(negedge clk);
        chk("R8 rc off", lfrc_en, 0);
        wdt_en = 1'b1;
        @(negedge clk);
        chk("R8 rc wdt", lfrc_en, 1);
        wdt_en = 1'b0; fscm_en = 1'b1;
        @(negedge clk);
        chk("R8 rc fscm", lfrc_en, 1);
        fscm_en = 1'b0;
        @(negedge clk);
        chk("R8 rc off again", lfrc_en, 0);
    endtask

    task automatic t_back_internal();
        mode_sel = 2'b10;
        @(negedge clk);
        chk("R11 pri kept", pri_osc_en, 1);
        for (int k = 0; k < 100 && pri_ready == 1'b1; k++) @(negedge clk);
        chk("R11 clk_sel", clk_sel, 1);
        chk("R11 int_stable", int_stable, 1);
        chk("R11 pri_osc_en", pri_osc_en, 0);
        chk("R11 gate", gate_en, 2);
    endtask

    task automatic t_pll();
        pll_en   = 1'b1;
        mode_sel = 2'b00;
        repeat (2400) @(negedge clk);
        chk("R6 wait lock", clk_sel, 1);
        chk("R6 pri_ready", pri_ready, 0);
        for (int k = 0; k < PLLN - 1; k++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk("R6 one short", clk_sel, 1);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        for (int k = 0; k < 60 && pri_ready == 1'b0; k++) @(negedge clk);
        chk("R6 locked", pri_ready, 1);
        chk("R6 clk_sel", clk_sel, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_rc();
        t_fast_on();
        t_stay_stable();
        t_midswitch();
        t_primary();
        t_rc_keep();
        t_back_internal();
        t_pll();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule